// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block turns a set of derived clock outputs on and off without runt pulses. There are two gated groups: CPU outputs, which run from the CPU source clock, and PCI outputs, which run from the PCI reference clock. There is also one free-running copy of each source. Each output has its own enable bit from the control registers. Each gated group also has an active-low stop pin, and the stop pins are honoured only when the mode input is low. An output runs only when its enable bit and its group's stop pin both allow it.

All control inputs are asynchronous to the clocks. They are resynchronised in the PCI reference domain and combined into a registered run decision there. Each output then takes up its new decision at a falling edge of its own source clock, and an AND gate passes the source clock to the output. As a result, a stopped output rests low, and every high phase it produces is a complete half period of its source.

Top module: `clkstop_top`

## Requirements
- R1: While `rst_n` is low, every output is low. After release, every output runs until the control inputs reach the run decision, which takes at least two reference rising edges, even when all enable bits are 0.
- R2: With `mode` = 1, the stop pins have no effect. Output `cpu_clk_o[i]` follows `cpu_run_en[i]`, `pci_clk_o[j]` follows `pci_run_en[j]`, `cpuf_clk_o` follows `cpuf_run_en`, and `pcif_clk_o` follows `pcif_run_en` (1 = run).
- R3: With `mode` = 0, each `cpu_clk_o[i]` runs only when `cpu_run_en[i]` = 1 and `cpu_stop_n` = 1. `cpu_stop_n` has no effect on the PCI or free-running outputs.
- R4: With `mode` = 0, each `pci_clk_o[j]` runs only when `pci_run_en[j]` = 1 and `pci_stop_n` = 1. The free-running outputs depend only on their own enable bits in every combination of `mode` and the stop pins.
- R5: A change on any control input leaves the outputs unchanged until the third rising edge of `pci_clk` after the change. The new state begins at the first falling edge of the output's source clock that follows that edge.
- R6: A stopped output holds logic low.
- R7: Every high pulse on an output lasts exactly one high phase of its source clock, including the last pulse before a stop and the first pulse after a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk | input | 1 | CPU source clock |
| pci_clk | input | 1 | Free-running PCI reference clock; also the source of the PCI outputs |
| mode | input | 1 | 0: stop pins active; 1: stop pins ignored |
| cpu_stop_n | input | 1 | Active-low stop for the gated CPU outputs |
| pci_stop_n | input | 1 | Active-low stop for the gated PCI outputs |
| cpu_run_en | input | N_CPU | Enable bits for the gated CPU outputs |
| pci_run_en | input | N_PCI | Enable bits for the gated PCI outputs |
| cpuf_run_en | input | 1 | Enable bit for the free-running CPU output |
| pcif_run_en | input | 1 | Enable bit for the free-running PCI output |
| cpu_clk_o | output | N_CPU | Gated CPU clock outputs |
| pci_clk_o | output | N_PCI | Gated PCI clock outputs |
| cpuf_clk_o | output | 1 | Free-running CPU clock output |
| pcif_clk_o | output | 1 | Free-running PCI clock output |

## Verification
Assertions in the reference domain check every cycle that the run decision obeys the mode, stop and enable combination (R2, R3, R4). An assertion at each gate checks that a captured enable is applied only at a falling edge of the source clock (R5). Other properties are visible only at the output pins: that no high pulse is cut short, that stopped outputs rest low, the exact delay before a change appears, and the behaviour just after reset. The bench shows these by sweeping all 2048 combinations of enables, mode and stop pins, counting edges and measuring each pulse width.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
    localparam int unsigned DEF_CPU_OUTS = 2;
    localparam int unsigned DEF_PCI_OUTS = 4;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Number of control bits besides the per-output enable vectors:
    // mode, two stop pins, two free-running enables.
    localparam int unsigned CTRL_EXTRA = 5;

    typedef struct packed {
        logic mode;
        logic cpu_stop_n;
        logic pci_stop_n;
    } pins_t;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = raw_i;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    // Reset to ones: everything reads as "run" until real values arrive.
    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_policy.sv
module clkstop_policy
    import clkstop_pkg::*;
#(
    parameter int unsigned NC = 2,
    parameter int unsigned NP = 4
) (
    input  logic          clk_i,
    input  logic          rst_n,
    input  pins_t         pins_i,
    input  logic [NC-1:0] cpu_en_i,
    input  logic [NP-1:0] pci_en_i,
    input  logic          cpuf_en_i,
    input  logic          pcif_en_i,
    output logic [NC-1:0] cpu_run_o,
    output logic [NP-1:0] pci_run_o,
    output logic          cpuf_run_o,
    output logic          pcif_run_o
);
    typedef struct packed {
        logic [NC-1:0] cpu;
        logic [NP-1:0] pci;
        logic          cpuf;
        logic          pcif;
    } run_t;

    run_t run_d, run_q;
    logic cpu_allow, pci_allow;

    always_comb begin
        cpu_allow  = pins_i.mode | pins_i.cpu_stop_n;
        pci_allow  = pins_i.mode | pins_i.pci_stop_n;
        run_d.cpu  = cpu_en_i & {NC{cpu_allow}};
        run_d.pci  = pci_en_i & {NP{pci_allow}};
        run_d.cpuf = cpuf_en_i;
        run_d.pcif = pcif_en_i;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) run_q <= '1;
        else        run_q <= run_d;
    end

    assign cpu_run_o  = run_q.cpu;
    assign pci_run_o  = run_q.pci;
    assign cpuf_run_o = run_q.cpuf;
    assign pcif_run_o = run_q.pcif;

    // R2
    mode_ignores_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        pins_i.mode |=> (pci_run_o == $past(pci_en_i)) && (cpu_run_o == $past(cpu_en_i)));

    // R3
    cpu_stop_forces_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        (!pins_i.mode && !pins_i.cpu_stop_n) |=> (cpu_run_o == '0));

    // R4
    free_follows_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        1'b1 |=> (pcif_run_o == $past(pcif_en_i)) && (cpuf_run_o == $past(cpuf_en_i)));
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate (
    input  logic clk_i,
    input  logic rst_n,
    input  logic en_i,
    output logic clk_o
);
    logic en_d, en_q;

    always_comb en_d = en_i;

    // Capture while the source is low, so the AND below can never cut a high phase.
    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign clk_o = clk_i & en_q;

    // R5
    en_at_fall_chk: assert property (@(negedge clk_i) disable iff (!rst_n)
        $stable(en_i) |=> (en_q == $past(en_i)));
endmodule

// File: rtl/clkstop_top.sv
module clkstop_top
    import clkstop_pkg::*;
#(
    parameter int unsigned N_CPU  = DEF_CPU_OUTS,
    parameter int unsigned N_PCI  = DEF_PCI_OUTS,
    parameter int unsigned STAGES = DEF_SYNC_STAGES
) (
    input  logic             rst_n,
    input  logic             cpu_clk,
    input  logic             pci_clk,
    input  logic             mode,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic [N_CPU-1:0] cpu_run_en,
    input  logic [N_PCI-1:0] pci_run_en,
    input  logic             cpuf_run_en,
    input  logic             pcif_run_en,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic             cpuf_clk_o,
    output logic             pcif_clk_o
);
    localparam int unsigned CW = N_CPU + N_PCI + CTRL_EXTRA;

    logic [CW-1:0]    raw_ctl, sync_ctl;
    pins_t            s_pins;
    logic [N_CPU-1:0] s_cpu, cpu_run;
    logic [N_PCI-1:0] s_pci, pci_run;
    logic             s_cpuf, s_pcif, cpuf_run, pcif_run;

    assign raw_ctl = {mode, cpu_stop_n, pci_stop_n, pcif_run_en, cpuf_run_en,
                      pci_run_en, cpu_run_en};

    clkstop_sync #(.W(CW), .STAGES(STAGES)) u_sync (
        .clk_i  (pci_clk),
        .rst_n  (rst_n),
        .raw_i  (raw_ctl),
        .sync_o (sync_ctl)
    );

    assign {s_pins, s_pcif, s_cpuf, s_pci, s_cpu} = sync_ctl;

    clkstop_policy #(.NC(N_CPU), .NP(N_PCI)) u_policy (
        .clk_i      (pci_clk),
        .rst_n      (rst_n),
        .pins_i     (s_pins),
        .cpu_en_i   (s_cpu),
        .pci_en_i   (s_pci),
        .cpuf_en_i  (s_cpuf),
        .pcif_en_i  (s_pcif),
        .cpu_run_o  (cpu_run),
        .pci_run_o  (pci_run),
        .cpuf_run_o (cpuf_run),
        .pcif_run_o (pcif_run)
    );

    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
        clkstop_gate u_gate (
            .clk_i (cpu_clk), .rst_n (rst_n), .en_i (cpu_run[i]), .clk_o (cpu_clk_o[i])
        );
    end

    for (genvar j = 0; j < N_PCI; j++) begin : g_pci
        clkstop_gate u_gate (
            .clk_i (pci_clk), .rst_n (rst_n), .en_i (pci_run[j]), .clk_o (pci_clk_o[j])
        );
    end

    clkstop_gate u_cpuf (
        .clk_i (cpu_clk), .rst_n (rst_n), .en_i (cpuf_run), .clk_o (cpuf_clk_o)
    );

    clkstop_gate u_pcif (
        .clk_i (pci_clk), .rst_n (rst_n), .en_i (pcif_run), .clk_o (pcif_clk_o)
    );
endmodule

// File: tb/sim_clkstop_top.sv
`timescale 1ns/1ps
module sim_clkstop_top;
    logic       rst_n = 1'b0;
    logic       cpu_clk = 1'b0;
    logic       pci_clk = 1'b0;
    logic       mode = 1'b0, cpu_stop_n = 1'b0, pci_stop_n = 1'b0;
    logic [1:0] cpu_run_en = '0;
    logic [3:0] pci_run_en = '0;
    logic       cpuf_run_en = 1'b0, pcif_run_en = 1'b0;
    logic [1:0] cpu_clk_o;
    logic [3:0] pci_clk_o;
    logic       cpuf_clk_o, pcif_clk_o;
    logic [7:0] outs;

    int  checks = 0;
    int  errors = 0;
    bit  mon_on = 0;
    bit  done = 0;
    int  rise_cnt [8];
    real rise_t [8];
    logic [7:0] prev_o = '0;

    clkstop_top u0 (
        .rst_n, .cpu_clk, .pci_clk, .mode, .cpu_stop_n, .pci_stop_n,
        .cpu_run_en, .pci_run_en, .cpuf_run_en, .pcif_run_en,
        .cpu_clk_o, .pci_clk_o, .cpuf_clk_o, .pcif_clk_o
    );

    assign outs = {pcif_clk_o, cpuf_clk_o, pci_clk_o, cpu_clk_o};

    always #2 pci_clk = ~pci_clk;               // 250 MHz reference
    initial begin
        #0.3;
        forever #1.5 cpu_clk = ~cpu_clk;        // unrelated CPU source
    end

    function automatic real half_of(int i);
        return (i < 2 || i == 6) ? 1.5 : 2.0;
    endfunction

    // R7: width of every high pulse on every output
    always @(outs) begin
        if (mon_on) begin
            for (int i = 0; i < 8; i++) begin
                if (prev_o[i] !== 1'b1 && outs[i] === 1'b1) begin
                    rise_cnt[i]++;
                    rise_t[i] = $realtime;
                end else if (prev_o[i] === 1'b1 && outs[i] !== 1'b1) begin
                    real w;
                    w = $realtime - rise_t[i];
                    checks++;
                    if (w - half_of(i) > 0.01 || half_of(i) - w > 0.01) begin
                        errors++;
                        $display("FAIL R7 out%0d pulse width actual %f expected %f", i, w, half_of(i));
                    end
                end
            end
        end
        prev_o = outs;
    end

    function automatic logic [7:0] expect_of(int v);
        logic [7:0] e;
        e[1:0] = v[1:0] & {2{v[8] | v[9]}};
        e[5:2] = v[5:2] & {4{v[8] | v[10]}};
        e[6]   = v[6];
        e[7]   = v[7];
        return e;
    endfunction

    function automatic string tag_of(int v, int i);
        if (v[8]) return "R2";
        if (i < 2) return "R3";
        return "R4";
    endfunction

    task automatic clear_counts();
        for (int i = 0; i < 8; i++) rise_cnt[i] = 0;
    endtask

    // R5: old state persists for the first reference edges after a change
    task automatic check_hold(logic [7:0] old_e);
        for (int i = 0; i < 8; i++) begin
            checks++;
            if ((rise_cnt[i] > 0) != old_e[i]) begin
                errors++;
                $display("FAIL R5 out%0d early change: rises %0d expected running=%0d",
                         i, rise_cnt[i], old_e[i]);
            end
        end
    endtask

    task automatic check_steady(int v, logic [7:0] e);
        for (int i = 0; i < 8; i++) begin
            checks++;
            if ((rise_cnt[i] > 0) != e[i]) begin
                errors++;
                $display("FAIL %s out%0d v=%0h rises %0d expected running=%0d",
                         tag_of(v, i), i, v, rise_cnt[i], e[i]);
            end
            if (!e[i]) begin
                checks++;
                if (outs[i] !== 1'b0) begin
                    errors++;
                    $display("FAIL R6 out%0d stopped level actual %b expected 0", i, outs[i]);
                end
            end
        end
    endtask

    task automatic apply(int v);
        cpu_run_en  = v[1:0];
        pci_run_en  = v[5:2];
        cpuf_run_en = v[6];
        pcif_run_en = v[7];
        mode        = v[8];
        cpu_stop_n  = v[9];
        pci_stop_n  = v[10];
    endtask

    initial begin
        logic [7:0] prev_e;
        // R1: outputs low during reset
        repeat (5) @(posedge pci_clk);
        #1;
        for (int i = 0; i < 8; i++) begin
            checks++;
            if (outs[i] !== 1'b0) begin
                errors++;
                $display("FAIL R1 out%0d in reset actual %b expected 0", i, outs[i]);
            end
        end
        // R1: release with all bits 0; outputs still run at first
        @(posedge pci_clk);
        #1;
        clear_counts();
        mon_on = 1;
        rst_n = 1'b1;
        #10;
        for (int i = 0; i < 8; i++) begin
            checks++;
            if (rise_cnt[i] == 0) begin
                errors++;
                $display("FAIL R1 out%0d after release rises %0d expected >0", i, rise_cnt[i]);
            end
        end
        #10;
        clear_counts();
        #32;
        check_steady(0, expect_of(0));
        prev_e = expect_of(0);
        // Exhaustive sweep over enables, mode and stop pins
        for (int v = 1; v < 2048; v++) begin
            @(posedge pci_clk);
            #1;
            clear_counts();
            apply(v);
            #10;
            check_hold(prev_e);
            #10;
            clear_counts();
            #32;
            check_steady(v, expect_of(v));
            prev_e = expect_of(v);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule